// File: doc/BRIEF.md
# Transparent Serial Frame Transmitter

This block turns a stream of bytes into an unformatted bit-serial frame. There are no flag sequences, start bits or stuffing. The only frame boundary a peer receiver sees is the request-to-send line (`tx_rts`). It goes high together with the first data bit and drops on the strobe after the final bit has been sent. The final bit is the last data bit, or the last CRC bit when the frame asks for a CRC. Bit timing comes entirely from `bit_en`, a one-cycle strobe from an external baud source. Outputs move only on cycles where the strobe is high.

Bytes arrive on a valid/ready interface. Each byte carries a last-of-frame flag. The CRC request and the bit order are taken from the first byte of the frame and held until the frame ends.

A two-bit clear-to-send mode chooses how the transmitter waits for the peer:
- **Ignore:** the CTS input plays no part.
- **Pulse:** one assertion of CTS releases a whole frame.
- **Envelope:** CTS must stay high for the whole frame. Losing it aborts the frame.

A frame also ends early when the next byte is not ready in time (an underrun). Both early ends raise a one-cycle `tx_abort` pulse.

Top module: `tframe_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_data` is 1 and `tx_rts` is 0. `tx_data` is never 0 while `tx_rts` is 0.
- R2: With `cts_mode` = 2'b00 (CTS ignored), the first `bit_en` cycle that finds `in_valid` high accepts the byte. On that edge `tx_rts` rises and `tx_data` carries the byte's first bit. The level of `cts` does not matter in this mode.
- R3: Each byte is sent least significant bit first when `msb_first` was 0 at the frame's first byte, and most significant bit first when it was 1. `tx_data` and `tx_rts` change only on edges where `bit_en` was high.
- R4: When `in_crc_en` is 1 with the first byte, 16 CRC bits follow the last data bit. The CRC is CRC-16-CCITT:
  - polynomial x^16+x^12+x^5+1, register preset to 0xFFFF;
  - computed over the data bits in the order they were sent;
  - sent complemented, register MSB first.
  When `in_crc_en` is 0, no CRC bits are sent.
- R5: `tx_rts` stays high without a gap across all bytes of a frame. It falls, and `tx_data` returns to 1, on the strobe after the final data or CRC bit. Exactly 8·N (+16) bits are sent while it is high.
- R6: `in_ready` is high only in `bit_en` cycles where the block can take a byte: at frame start, or when the current byte's last bit is leaving and more bytes follow. Every byte of a frame is accepted exactly once.
- R7: With `cts_mode` = 2'b01 (pulse), CTS high for even one cycle while idle arms the transmitter. The next frame then starts and runs to its end whatever CTS does afterwards.
- R8: With `cts_mode` = 2'b10 (envelope), a frame starts only while `cts` is 1. If `cts` is 0 on a strobe during a frame:
  - `tx_rts` falls on that edge and `tx_data` returns to 1;
  - `tx_abort` is high for exactly one cycle.
- R9: If no byte is valid when the current byte's last bit is leaving and the frame has not ended:
  - the frame ends on that edge and `tx_rts` falls;
  - `tx_abort` pulses for one cycle.
- R10: In pulse mode with no arming, or in envelope mode with `cts` at 0, an idle transmitter does not start: `in_ready` stays 0 and `tx_rts` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle bit strobe |
| cts_mode | input | 2 | 00 ignore, 01 pulse, 10 envelope, 11 treated as ignore |
| cts | input | 1 | Clear-to-send from the peer, active high, synchronous to clk |
| msb_first | input | 1 | Bit order for the frame, sampled with the first byte |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte is valid |
| in_last | input | 1 | Byte is the last of its frame |
| in_crc_en | input | 1 | Append CRC to this frame, sampled with the first byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| tx_data | output | 1 | Serial data line |
| tx_rts | output | 1 | Frame envelope for the peer |
| tx_abort | output | 1 | One-cycle pulse on envelope loss or underrun |

## Verification
Some behaviours are checked by assertions on every cycle:
- the line is high whenever RTS is low;
- the outputs are frozen between strobes;
- `in_ready` appears only with a strobe;
- the abort pulse lasts a single cycle;
- envelope loss drops RTS on the next edge;
- no envelope-mode frame starts without CTS.

Other behaviours need the bench's scenarios, which compare each captured serial stream with a reference built from the requirements:
- the serial contents themselves (bit order, CRC value and length);
- pulse-mode arming across a CTS pulse;
- the exact bit count at which an underrun or abort truncates a frame.

// File: rtl/tframe_pkg.sv
// Package: shared encodings and constants for the transparent frame transmitter.
// Assumes: all users compile this package first.
package tframe_pkg;

    // Clear-to-send handling selected by the two-bit mode input.
    typedef enum logic [1:0] {
        CTS_IGNORE   = 2'b00,
        CTS_PULSE    = 2'b01,
        CTS_ENVELOPE = 2'b10
    } cts_mode_e;

    // Transmitter sequencing.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_DATA = 2'b01,
        ST_CRC  = 2'b10
    } tx_state_e;

    localparam logic [15:0] CCITT_POLY   = 16'h1021;
    localparam logic [15:0] CCITT_PRESET = 16'hFFFF;

endpackage

// File: rtl/tframe_crc16.sv
// Module: serial CRC register for the transmitter.
// Function: loads the preset and folds in one bit, folds in further bits, or
// shifts out its contents MSB first; out_bit is the complement of the top bit.
// Assumes: at most one of start/step/shift is high in a cycle (start wins).
module tframe_crc16 #(
    parameter int          CRC_W  = 16,
    parameter logic [15:0] POLY   = 16'h1021,
    parameter logic [15:0] PRESET = 16'hFFFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic step,
    input  logic shift,
    input  logic bit_in,
    output logic out_bit
);

    logic [CRC_W-1:0] crc_q;

    // One CRC step for a single data bit.
    function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
    endfunction

    // Register update: preset+fold, fold, or shift toward the output.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= PRESET[CRC_W-1:0];
        else if (start)  crc_q <= fold(PRESET[CRC_W-1:0], bit_in);
        else if (step)   crc_q <= fold(crc_q, bit_in);
        else if (shift)  crc_q <= {crc_q[CRC_W-2:0], 1'b0};
    end

    assign out_bit = ~crc_q[CRC_W-1];

endmodule

// File: rtl/tframe_cts.sv
// Module: clear-to-send qualifier.
// Function: says whether an idle transmitter may start (may_start) and whether
// a running frame has lost its envelope (lost). In pulse mode a CTS assertion
// seen while idle is remembered until a frame starts.
// Assumes: cts is already synchronous to clk.
module tframe_cts
    import tframe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       cts,
    input  logic       idle,
    input  logic       frame_start,
    output logic       may_start,
    output logic       lost
);

    logic armed_q;

    // Pulse-mode arming latch, cleared when a frame starts or the mode changes.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   armed_q <= 1'b0;
        else if (frame_start || mode != CTS_PULSE)    armed_q <= 1'b0;
        else if (idle && cts)                         armed_q <= 1'b1;
    end

    // Start permission and envelope-loss decode.
    always_comb begin
        case (mode)
            CTS_PULSE:    may_start = cts | armed_q;
            CTS_ENVELOPE: may_start = cts;
            default:      may_start = 1'b1;
        endcase
        lost = (mode == CTS_ENVELOPE) && !cts;
    end

    // R10: an envelope-mode frame never begins without CTS.
    p_env_start_needs_cts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && mode == CTS_ENVELOPE) |-> cts);

endmodule

// File: rtl/tframe_tx.sv
// Module: transparent serial frame transmitter (top).
// Function: accepts bytes on valid/ready, shifts them out one bit per bit_en
// strobe framed by tx_rts, optionally appends a complemented CRC-16-CCITT, and
// ends early with a tx_abort pulse on envelope loss or underrun.
// Assumes: bit_en is a single-cycle strobe; cts is synchronous to clk.
module tframe_tx
    import tframe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [1:0]        cts_mode,
    input  logic              cts,
    input  logic              msb_first,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              in_crc_en,
    output logic              in_ready,
    output logic              tx_data,
    output logic              tx_rts,
    output logic              tx_abort
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int CNT_W = $clog2(CRC_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CRC_W - 1);

    tx_state_e         state_q;
    logic [DATA_W-1:0] byte_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  ccnt_q;
    logic              last_q, crcen_q, msb_q;
    logic              txd_q, rts_q, abort_q;

    logic may_start, lost, start, lost_now, end_of_byte, need_byte;
    logic nxt_bit, crc_out, crc_step, crc_shift;

    // Bit selected from a byte by position and order.
    function automatic logic bit_of(input logic [DATA_W-1:0] b,
                                    input logic [IDX_W-1:0] i, input logic msb);
        return msb ? b[IDX_LAST - i] : b[i];
    endfunction

    tframe_cts u_cts (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (cts_mode),
        .cts         (cts),
        .idle        (state_q == ST_IDLE),
        .frame_start (start),
        .may_start   (may_start),
        .lost        (lost)
    );

    // Strobe-qualified control decode.
    always_comb begin
        end_of_byte = (idx_q == IDX_LAST);
        need_byte   = (state_q == ST_DATA) && end_of_byte && !last_q;
        start       = bit_en && (state_q == ST_IDLE) && may_start && in_valid;
        lost_now    = bit_en && lost && (state_q != ST_IDLE);
        in_ready    = bit_en && (((state_q == ST_IDLE) && may_start) || (need_byte && !lost));
        if (state_q == ST_IDLE)  nxt_bit = bit_of(in_data, '0, msb_first);
        else if (end_of_byte)    nxt_bit = bit_of(in_data, '0, msb_q);
        else                     nxt_bit = bit_of(byte_q, idx_q + IDX_W'(1), msb_q);
        crc_step  = bit_en && !lost && (state_q == ST_DATA) &&
                    (!end_of_byte || (need_byte && in_valid));
        crc_shift = bit_en && !lost &&
                    (((state_q == ST_DATA) && end_of_byte && last_q && crcen_q) ||
                     ((state_q == ST_CRC) && ccnt_q != CNT_LAST));
    end

    tframe_crc16 #(
        .CRC_W  (CRC_W),
        .POLY   (CCITT_POLY),
        .PRESET (CCITT_PRESET)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .step    (crc_step),
        .shift   (crc_shift),
        .bit_in  (nxt_bit),
        .out_bit (crc_out)
    );

    // Frame sequencer: all progress happens on strobe cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= '0;
            idx_q   <= '0;
            ccnt_q  <= '0;
            last_q  <= 1'b0;
            crcen_q <= 1'b0;
            msb_q   <= 1'b0;
            txd_q   <= 1'b1;
            rts_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            abort_q <= 1'b0;
            if (bit_en) begin
                case (state_q)
                    ST_IDLE: begin
                        if (start) begin
                            byte_q  <= in_data;
                            idx_q   <= '0;
                            last_q  <= in_last;
                            crcen_q <= in_crc_en;
                            msb_q   <= msb_first;
                            txd_q   <= nxt_bit;
                            rts_q   <= 1'b1;
                            state_q <= ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (lost_now) begin
                            state_q <= ST_IDLE; rts_q <= 1'b0; txd_q <= 1'b1; abort_q <= 1'b1;
                        end else if (!end_of_byte) begin
                            idx_q <= idx_q + IDX_W'(1);
                            txd_q <= nxt_bit;
                        end else if (!last_q) begin
                            if (in_valid) begin
                                byte_q <= in_data;
                                idx_q  <= '0;
                                last_q <= in_last;
                                txd_q  <= nxt_bit;
                            end else begin
                                state_q <= ST_IDLE; rts_q <= 1'b0; txd_q <= 1'b1; abort_q <= 1'b1;
                            end
                        end else if (crcen_q) begin
                            state_q <= ST_CRC;
                            ccnt_q  <= '0;
                            txd_q   <= crc_out;
                        end else begin
                            state_q <= ST_IDLE; rts_q <= 1'b0; txd_q <= 1'b1;
                        end
                    end
                    ST_CRC: begin
                        if (lost_now) begin
                            state_q <= ST_IDLE; rts_q <= 1'b0; txd_q <= 1'b1; abort_q <= 1'b1;
                        end else if (ccnt_q == CNT_LAST) begin
                            state_q <= ST_IDLE; rts_q <= 1'b0; txd_q <= 1'b1;
                        end else begin
                            ccnt_q <= ccnt_q + CNT_W'(1);
                            txd_q  <= crc_out;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign tx_data  = txd_q;
    assign tx_rts   = rts_q;
    assign tx_abort = abort_q;

    // R1: the line rests high whenever no frame is framed by RTS.
    p_line_high_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_rts |-> tx_data);

    // R3: outputs hold between strobes.
    p_hold_between_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(tx_data) && $stable(tx_rts)));

    // R6: bytes are only taken on strobe cycles.
    p_ready_with_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> bit_en);

    // R8: envelope loss ends the frame on that strobe with an abort pulse.
    p_env_loss_aborts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_mode == CTS_ENVELOPE && tx_rts && bit_en && !cts) |=> (!tx_rts && tx_abort));

    // R9: the abort indication lasts one cycle.
    p_abort_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !tx_abort);

endmodule

// File: tb/tframe_tx_tb.sv
`timescale 1ns/1ps
module tframe_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n, bit_en, cts, msb_first, in_valid, in_last, in_crc_en;
    logic [1:0] cts_mode;
    logic [7:0] in_data;
    logic       in_ready, tx_data, tx_rts, tx_abort;

    int nchk = 0, nfail = 0;
    logic [7:0] frame_q[$];
    bit exp_q[$], got_q[$];
    int aborts, accepted;

    always #2 clk = ~clk;

    tframe_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cts_mode(cts_mode), .cts(cts),
        .msb_first(msb_first), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_crc_en(in_crc_en), .in_ready(in_ready), .tx_data(tx_data), .tx_rts(tx_rts),
        .tx_abort(tx_abort)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference serial stream for frame_q, per R3/R4.
    function automatic void build_expected(input bit crc, input bit msb);
        logic [15:0] c = 16'hFFFF;
        exp_q.delete();
        foreach (frame_q[k]) begin
            for (int i = 0; i < 8; i++) begin
                bit b = msb ? frame_q[k][7-i] : frame_q[k][i];
                bit fb = c[15] ^ b;
                exp_q.push_back(b);
                c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        end
        if (crc) for (int i = 15; i >= 0; i--) exp_q.push_back(~c[i]);
    endfunction

    // Compare the first n captured bits with the reference.
    task automatic cmp_bits(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (i >= got_q.size() || i >= exp_q.size() || got_q[i] != exp_q[i]) bad++;
        chk(bad == 0, req, "serial bit mismatches", bad, 0);
    endtask

    // Drive frame_q through the block and capture the bits framed by RTS.
    task automatic run_frame(input bit crc, input bit msb, input int gap,
                             input int hold_idx, input int cts_drop_at);
        int idx = 0, guard = 0, n = frame_q.size();
        bit done = 0, rts_prev = 0, fire, en;
        got_q.delete(); aborts = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            in_valid = (idx < n) && (idx < hold_idx);
            in_data  = (idx < n) ? frame_q[idx] : 8'h00;
            in_last  = (idx == n - 1);
            in_crc_en = crc;
            msb_first = msb;
            if (cts_drop_at >= 0 && got_q.size() >= cts_drop_at) cts = 1'b0;
            en = ($urandom_range(gap - 1, 0) == 0);
            bit_en = en;
            #1 fire = in_valid && in_ready;
            @(posedge clk);
            if (fire) idx++;
            #1;
            if (tx_abort) aborts++;
            if (en && tx_rts) got_q.push_back(tx_data);
            if (rts_prev && !tx_rts) done = 1;
            rts_prev = tx_rts;
            guard++;
        end
        accepted = idx;
        @(negedge clk);
        in_valid = 0; bit_en = 0;
        @(posedge clk); #1;
        if (tx_abort) aborts++;
        chk(done, "R5", "frame ended", done, 1);
    endtask

    initial begin
        #(200000 * 4);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; bit_en = 0; cts = 0; cts_mode = 2'b00; msb_first = 0;
        in_data = 0; in_valid = 0; in_last = 0; in_crc_en = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        chk(tx_data == 1'b1, "R1", "reset txd", tx_data, 1);
        chk(tx_rts == 1'b0, "R1", "reset rts", tx_rts, 0);
        chk(tx_abort == 1'b0, "R1", "reset abort", tx_abort, 0);
        chk(in_ready == 1'b0, "R6", "reset ready", in_ready, 0);

        // R2/R3: single byte, LSB first, CTS ignored with cts low.
        frame_q = '{8'hA5};
        build_expected(0, 0);
        run_frame(0, 0, 1, 99, -1);
        chk(got_q.size() == 8, "R5", "bit count", got_q.size(), 8);
        cmp_bits(8, "R2");
        chk(tx_data == 1'b1 && tx_rts == 1'b0, "R1", "idle after frame", tx_data, 1);

        // R3/R4: MSB first with CRC, slow strobe.
        frame_q = '{8'h31, 8'hC4, 8'h0F};
        build_expected(1, 1);
        run_frame(1, 1, 4, 99, -1);
        chk(got_q.size() == exp_q.size(), "R4", "bit count with CRC", got_q.size(), exp_q.size());
        cmp_bits(exp_q.size(), "R4");

        // Random frames in ignore mode: R3, R4, R5, R6.
        for (int f = 0; f < 24; f++) begin
            int len = $urandom_range(5, 1);
            bit crc = $urandom_range(1, 0);
            bit msb = $urandom_range(1, 0);
            frame_q.delete();
            for (int k = 0; k < len; k++) frame_q.push_back(8'($urandom_range(255, 0)));
            build_expected(crc, msb);
            run_frame(crc, msb, $urandom_range(4, 1), 99, -1);
            chk(got_q.size() == exp_q.size(), "R5", "random bit count", got_q.size(), exp_q.size());
            cmp_bits(exp_q.size(), "R3");
            chk(accepted == len, "R6", "bytes accepted", accepted, len);
            chk(aborts == 0, "R5", "no abort on clean frame", aborts, 0);
            repeat ($urandom_range(6, 0)) @(posedge clk);
        end

        // R10: envelope and unarmed pulse modes with cts low never start.
        for (int m = 1; m <= 2; m++) begin
            int rdy = 0, rts_seen = 0;
            @(negedge clk);
            cts_mode = 2'(m); cts = 0;
            in_valid = 1; in_data = 8'h55; in_last = 1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk) bit_en = 1;
                #1 if (in_ready) rdy++;
                @(posedge clk) #1 if (tx_rts) rts_seen++;
            end
            @(negedge clk) bit_en = 0; in_valid = 0;
            chk(rdy == 0, "R10", "ready while blocked", rdy, 0);
            chk(rts_seen == 0, "R10", "rts while blocked", rts_seen, 0);
        end

        // R7: one-cycle CTS pulse arms a full frame; CTS low afterwards.
        @(negedge clk) cts_mode = 2'b01; cts = 1;
        @(negedge clk) cts = 0;
        repeat (3) @(posedge clk);
        frame_q = '{8'h12, 8'h9E};
        build_expected(1, 0);
        run_frame(1, 0, 2, 99, -1);
        chk(got_q.size() == exp_q.size(), "R7", "pulse-mode bit count", got_q.size(), exp_q.size());
        cmp_bits(exp_q.size(), "R7");
        chk(aborts == 0, "R7", "no abort in pulse mode", aborts, 0);

        // R8: envelope held for whole frame.
        @(negedge clk) cts_mode = 2'b10; cts = 1;
        frame_q = '{8'hF0, 8'h3C};
        build_expected(1, 0);
        run_frame(1, 0, 2, 99, -1);
        chk(got_q.size() == exp_q.size(), "R8", "envelope bit count", got_q.size(), exp_q.size());
        cmp_bits(exp_q.size(), "R8");

        // R8: CTS dropped after 5 bits aborts the frame.
        frame_q = '{8'hC3, 8'h77, 8'h01};
        build_expected(0, 0);
        run_frame(0, 0, 2, 99, 5);
        chk(got_q.size() == 5, "R8", "bits before abort", got_q.size(), 5);
        cmp_bits(5, "R8");
        chk(aborts == 1, "R8", "abort pulse cycles", aborts, 1);
        chk(tx_data == 1'b1 && tx_rts == 1'b0, "R8", "line idle after abort", tx_data, 1);

        // R9: underrun after the first byte.
        @(negedge clk) cts_mode = 2'b00; cts = 0;
        frame_q = '{8'h6B, 8'h22, 8'h90};
        build_expected(1, 1);
        run_frame(1, 1, 2, 1, -1);
        chk(got_q.size() == 8, "R9", "bits before underrun", got_q.size(), 8);
        cmp_bits(8, "R9");
        chk(aborts == 1, "R9", "underrun pulse cycles", aborts, 1);
        chk(tx_rts == 1'b0, "R9", "rts after underrun", tx_rts, 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule